// File: doc/BRIEF.md
# MOESI Coherence Controller with Owner Forwarding

This controller keeps the coherence state of every line in one private cache. It implements a five-state protocol: Invalid, Shared, Exclusive, Owned and Modified. The Owned state lets a dirty line be shared between caches while memory stays stale. Memory is updated only when a dirty line leaves a cache by eviction. Until then, the cache that holds the dirty copy is its owner. The owner answers every miss that another cache makes on that line. It sends the data straight to the requester and holds memory off the bus. When the miss is a plain read, ownership moves to the reader, and the former holder keeps a Shared copy.

The local side takes one request per cycle: read, write, evict, or a no-op code. Most requests are served with no bus traffic. The others produce a bus request or an eviction writeback. The snoop side takes bus requests made by other caches and returns three results: a shared indication, a forward strobe and a memory-inhibit signal. Every output is a function of the inputs and the stored state in the same cycle. The line state changes at the next clock edge. The peer responses for a local read miss (shared, forwarded) are sampled in the same cycle as the bus request. Local requests and snoops are expected on different cycles. If both arrive together, the snoop's state update takes precedence.

Top module: `moesi_owner_ctrl`

## Requirements
- R1: After reset every line is Invalid. No output is active without stimulus, no snoop gets a response, and the first access to a line goes to the bus.
- R2: A local read (op 0) to an Invalid line issues a bus read (op 1) on the same line. The line then becomes Owned if a peer forwarded, Shared if a peer only reported a copy, and otherwise Exclusive (with the default exclusive-fill setting).
- R3: A local read to a line in Shared, Exclusive, Owned or Modified issues no bus request and leaves the state unchanged.
- R4: A local write (op 1) issues a read-exclusive (op 2) from Invalid and an upgrade (op 3) from Shared or Owned. It issues nothing from Exclusive or Modified. In every case the line ends in Modified.
- R5: A snooped read to an Owned or Modified line raises the forward strobe, memory-inhibit and shared outputs in that cycle. The line then becomes Shared, so ownership passes to the reader.
- R6: A snooped read to an Exclusive or Shared line raises only the shared output, and the line becomes Shared.
- R7: A snooped read-exclusive invalidates the line. An Owned or Modified holder first forwards with memory-inhibit; an Exclusive or Shared holder stays silent.
- R8: A snooped upgrade invalidates a Shared or Owned line without forwarding or reporting shared.
- R9: A local evict (op 2) raises the writeback strobe, with the line index, only for an Owned or Modified line. In every case the line ends Invalid.
- R10: A snoop to an Invalid line produces no response and leaves it Invalid.
- R11: Local op code 3 produces no output and changes no state.
- R12: Among controllers sharing one bus, at most one forwards for any miss. Memory supplies data only when none forwards, and memory is written only through eviction writebacks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lreq_valid_i | input | 1 | Local request present |
| lreq_op_i | input | 2 | Local op: 0 read, 1 write, 2 evict, 3 no-op |
| lreq_line_i | input | IDX_W | Local request line index |
| peer_shared_i | input | 1 | Some peer keeps a copy (for this cycle's bus read) |
| peer_fwd_i | input | 1 | A peer owner forwarded data (for this cycle's bus read) |
| snp_valid_i | input | 1 | Snooped bus request present |
| snp_op_i | input | 2 | Snooped op: 1 read, 2 read-exclusive, 3 upgrade |
| snp_line_i | input | IDX_W | Snooped line index |
| bus_req_valid_o | output | 1 | Bus request issued |
| bus_req_op_o | output | 2 | Bus op: 1 read, 2 read-exclusive, 3 upgrade |
| bus_req_line_o | output | IDX_W | Bus request line index |
| snp_shared_o | output | 1 | Copy held, reported on a snooped read |
| fwd_o | output | 1 | Cache-to-cache data forward strobe |
| mem_inhibit_o | output | 1 | Memory must not respond |
| wb_valid_o | output | 1 | Eviction writeback strobe |
| wb_line_o | output | IDX_W | Writeback line index |

## Verification
Bus requests, writebacks, forward strobes, memory-inhibit and the shared indication are all due in the same cycle as the stimulus that causes them. The new line state is due at the following clock edge. The bench therefore drives a request shortly after a rising edge and compares every output at the falling edge of that same cycle. A state change shows up only through the outputs of a later request, which is issued at least one edge after the update. Three controllers share a modelled bus, so each snooped result and each ownership handoff is observed at the ports of both the requesting controller and the responding controller.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

   typedef enum logic [2:0] {
      ST_I = 3'd0,
      ST_S = 3'd1,
      ST_E = 3'd2,
      ST_O = 3'd3,
      ST_M = 3'd4
   } line_st_t;

   localparam logic [1:0] LOC_RD  = 2'd0;
   localparam logic [1:0] LOC_WR  = 2'd1;
   localparam logic [1:0] LOC_EV  = 2'd2;
   localparam logic [1:0] LOC_NOP = 2'd3;

   localparam logic [1:0] BUS_NONE = 2'd0;
   localparam logic [1:0] BUS_RD   = 2'd1;
   localparam logic [1:0] BUS_RDX  = 2'd2;
   localparam logic [1:0] BUS_UPG  = 2'd3;

   function automatic logic st_dirty(line_st_t s);
      return (s == ST_O) || (s == ST_M);
   endfunction

endpackage

// File: rtl/moesi_line_store.sv
module moesi_line_store
   import moesi_pkg::*;
#(
   parameter int NLINES = 16,
   localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  line_st_t         wdata,
   input  logic [IDX_W-1:0] raddr_a,
   output line_st_t         rdata_a,
   input  logic [IDX_W-1:0] raddr_b,
   output line_st_t         rdata_b
);

   line_st_t          st_q [NLINES];
   logic [NLINES-1:0] wen;

   for (genvar i = 0; i < NLINES; i++) begin : g_wen
      assign wen[i] = we && (waddr == IDX_W'(i));
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < NLINES; i++) begin
         if (!rst_n)
            st_q[i] <= ST_I;
         else if (wen[i])
            st_q[i] <= wdata;
      end
   end

   assign rdata_a = st_q[raddr_a];
   assign rdata_b = st_q[raddr_b];

endmodule

// File: rtl/moesi_local_fsm.sv
module moesi_local_fsm
   import moesi_pkg::*;
#(
   parameter bit EXCL_FILL = 1'b1
) (
   input  logic       req_v,
   input  logic [1:0] req_op,
   input  line_st_t   cur,
   input  logic       peer_sh,
   input  logic       peer_fwd,
   output logic       bus_v,
   output logic [1:0] bus_op,
   output logic       wb,
   output logic       upd,
   output line_st_t   nxt
);

   line_st_t clean_fill;

   if (EXCL_FILL) begin : g_fill_excl
      assign clean_fill = ST_E;
   end else begin : g_fill_shared
      assign clean_fill = ST_S;
   end

   // bus-facing outputs never depend on peer responses
   always_comb begin : bus_side
      bus_v  = 1'b0;
      bus_op = BUS_NONE;
      wb     = 1'b0;
      if (req_v) begin
         case (req_op)
            LOC_RD: begin
               if (cur == ST_I) begin
                  bus_v  = 1'b1;
                  bus_op = BUS_RD;
               end
            end
            LOC_WR: begin
               if (cur == ST_I) begin
                  bus_v  = 1'b1;
                  bus_op = BUS_RDX;
               end else if (cur == ST_S || cur == ST_O) begin
                  bus_v  = 1'b1;
                  bus_op = BUS_UPG;
               end
            end
            LOC_EV:  wb = st_dirty(cur);
            default: ;
         endcase
      end
   end

   always_comb begin : state_side
      nxt = cur;
      if (req_v) begin
         case (req_op)
            LOC_RD: begin
               if (cur == ST_I)
                  nxt = peer_fwd ? ST_O : (peer_sh ? ST_S : clean_fill);
            end
            LOC_WR:  nxt = ST_M;
            LOC_EV:  nxt = ST_I;
            default: ;
         endcase
      end
      upd = req_v && (nxt != cur);
   end

endmodule

// File: rtl/moesi_snoop_fsm.sv
module moesi_snoop_fsm
   import moesi_pkg::*;
(
   input  logic       snp_v,
   input  logic [1:0] snp_op,
   input  line_st_t   cur,
   output logic       sh,
   output logic       supply,
   output logic       inhibit,
   output logic       upd,
   output line_st_t   nxt
);

   logic owner_hit;

   always_comb begin : reply
      sh     = 1'b0;
      supply = 1'b0;
      nxt    = cur;
      if (snp_v && cur != ST_I) begin
         case (snp_op)
            BUS_RD: begin
               sh     = 1'b1;
               supply = st_dirty(cur);
               nxt    = ST_S;
            end
            BUS_RDX: begin
               supply = st_dirty(cur);
               nxt    = ST_I;
            end
            BUS_UPG: nxt = ST_I;
            default: ;
         endcase
      end
      upd = nxt != cur;
   end

   // memory hold-off: owner present and memory would otherwise return data
   assign owner_hit = snp_v && st_dirty(cur);
   assign inhibit   = owner_hit && (snp_op == BUS_RD || snp_op == BUS_RDX);

endmodule

// File: rtl/moesi_owner_ctrl.sv
module moesi_owner_ctrl
   import moesi_pkg::*;
#(
   parameter int NLINES    = 16,
   parameter bit EXCL_FILL = 1'b1,
   localparam int IDX_W    = (NLINES > 1) ? $clog2(NLINES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lreq_valid_i,
   input  logic [1:0]       lreq_op_i,
   input  logic [IDX_W-1:0] lreq_line_i,
   input  logic             peer_shared_i,
   input  logic             peer_fwd_i,
   input  logic             snp_valid_i,
   input  logic [1:0]       snp_op_i,
   input  logic [IDX_W-1:0] snp_line_i,
   output logic             bus_req_valid_o,
   output logic [1:0]       bus_req_op_o,
   output logic [IDX_W-1:0] bus_req_line_o,
   output logic             snp_shared_o,
   output logic             fwd_o,
   output logic             mem_inhibit_o,
   output logic             wb_valid_o,
   output logic [IDX_W-1:0] wb_line_o
);

   if (NLINES < 2 || (NLINES & (NLINES - 1)) != 0) begin : g_bad_nlines
      $error("moesi_owner_ctrl: NLINES must be a power of two, at least 2");
   end

   line_st_t loc_cur, loc_nxt, snp_cur, snp_nxt, wr_state;
   logic     loc_upd, snp_upd, st_we;
   logic [IDX_W-1:0] wr_line;

   moesi_line_store #(.NLINES(NLINES)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (st_we),
      .waddr   (wr_line),
      .wdata   (wr_state),
      .raddr_a (lreq_line_i),
      .rdata_a (loc_cur),
      .raddr_b (snp_line_i),
      .rdata_b (snp_cur)
   );

   moesi_local_fsm #(.EXCL_FILL(EXCL_FILL)) u_local (
      .req_v    (lreq_valid_i),
      .req_op   (lreq_op_i),
      .cur      (loc_cur),
      .peer_sh  (peer_shared_i),
      .peer_fwd (peer_fwd_i),
      .bus_v    (bus_req_valid_o),
      .bus_op   (bus_req_op_o),
      .wb       (wb_valid_o),
      .upd      (loc_upd),
      .nxt      (loc_nxt)
   );

   moesi_snoop_fsm u_snoop (
      .snp_v   (snp_valid_i),
      .snp_op  (snp_op_i),
      .cur     (snp_cur),
      .sh      (snp_shared_o),
      .supply  (fwd_o),
      .inhibit (mem_inhibit_o),
      .upd     (snp_upd),
      .nxt     (snp_nxt)
   );

   // single state write port; a snoop update wins over a local one
   always_comb begin
      st_we    = snp_upd || loc_upd;
      wr_line  = snp_upd ? snp_line_i : lreq_line_i;
      wr_state = snp_upd ? snp_nxt : loc_nxt;
   end

   assign bus_req_line_o = lreq_line_i;
   assign wb_line_o      = lreq_line_i;

endmodule

// File: rtl/moesi_owner_chk.sv
module moesi_owner_chk #(
   parameter int IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lreq_valid_i,
   input logic [1:0]       lreq_op_i,
   input logic [IDX_W-1:0] lreq_line_i,
   input logic             snp_valid_i,
   input logic [1:0]       snp_op_i,
   input logic [IDX_W-1:0] snp_line_i,
   input logic             bus_req_valid_o,
   input logic [IDX_W-1:0] bus_req_line_o,
   input logic             snp_shared_o,
   input logic             fwd_o,
   input logic             mem_inhibit_o,
   input logic             wb_valid_o
);

   // R9
   wb_only_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid_o |-> (lreq_valid_i && lreq_op_i == 2'd2));

   // R2
   bus_from_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid_o |-> (lreq_valid_i && (lreq_op_i == 2'd0 || lreq_op_i == 2'd1)
                           && bus_req_line_o == lreq_line_i));

   // R10
   idle_snoop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !snp_valid_i |-> !(fwd_o || snp_shared_o || mem_inhibit_o));

   // R5
   fwd_holds_memory_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_o |-> (mem_inhibit_o && snp_op_i != 2'd3));

   // R8
   upgrade_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid_i && snp_op_i == 2'd3) |-> !(fwd_o || snp_shared_o));

   // R7
   readx_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid_i && snp_op_i == 2'd2) ##1
      (snp_valid_i && snp_line_i == $past(snp_line_i))
      |-> !(snp_shared_o || fwd_o));

   // R4
   write_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lreq_valid_i && lreq_op_i == 2'd1 && !snp_valid_i) ##1
      (lreq_valid_i && lreq_line_i == $past(lreq_line_i) && lreq_op_i != 2'd2 && !snp_valid_i)
      |-> !bus_req_valid_o);

   // R9
   evict_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lreq_valid_i && lreq_op_i == 2'd2 && !snp_valid_i) ##1
      (lreq_valid_i && lreq_op_i == 2'd0 && lreq_line_i == $past(lreq_line_i) && !snp_valid_i)
      |-> bus_req_valid_o);

endmodule

bind moesi_owner_ctrl moesi_owner_chk #(.IDX_W(IDX_W)) u_owner_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .lreq_valid_i    (lreq_valid_i),
   .lreq_op_i       (lreq_op_i),
   .lreq_line_i     (lreq_line_i),
   .snp_valid_i     (snp_valid_i),
   .snp_op_i        (snp_op_i),
   .snp_line_i      (snp_line_i),
   .bus_req_valid_o (bus_req_valid_o),
   .bus_req_line_o  (bus_req_line_o),
   .snp_shared_o    (snp_shared_o),
   .fwd_o           (fwd_o),
   .mem_inhibit_o   (mem_inhibit_o),
   .wb_valid_o      (wb_valid_o)
);

// File: tb/moesi_owner_ctrl_test.sv
module moesi_owner_ctrl_test;

   localparam int NC = 3;
   localparam int NL = 4;
   localparam int IW = 2;
   // bench-side state codes
   localparam int I = 0, S = 1, E = 2, O = 3, M = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          lv  [NC];
   logic [1:0]    lop [NC];
   logic [IW-1:0] lln [NC];
   logic          rsh [NC];
   logic          rfw [NC];
   logic          sv  [NC];
   logic [1:0]    sop [NC];
   logic [IW-1:0] sln [NC];
   logic          bv  [NC];
   logic [1:0]    bop [NC];
   logic [IW-1:0] bln [NC];
   logic          ssh [NC];
   logic          fw  [NC];
   logic          inh [NC];
   logic          wbv [NC];
   logic [IW-1:0] wbl [NC];

   int cur = 0;

   for (genvar c = 0; c < NC; c++) begin : g_node
      moesi_owner_ctrl #(.NLINES(NL)) uut (
         .clk (clk), .rst_n (rst_n),
         .lreq_valid_i (lv[c]), .lreq_op_i (lop[c]), .lreq_line_i (lln[c]),
         .peer_shared_i (rsh[c]), .peer_fwd_i (rfw[c]),
         .snp_valid_i (sv[c]), .snp_op_i (sop[c]), .snp_line_i (sln[c]),
         .bus_req_valid_o (bv[c]), .bus_req_op_o (bop[c]), .bus_req_line_o (bln[c]),
         .snp_shared_o (ssh[c]), .fwd_o (fw[c]), .mem_inhibit_o (inh[c]),
         .wb_valid_o (wbv[c]), .wb_line_o (wbl[c])
      );
   end

   // bus fan-out of the active requester
   always_comb begin
      for (int c = 0; c < NC; c++) begin
         sv[c]  = (c != cur) && bv[cur];
         sop[c] = bop[cur];
         sln[c] = bln[cur];
      end
   end

   logic any_sh, any_fw, any_inh, mem_supply;
   int   n_fw;
   always_comb begin
      any_sh = 1'b0; any_fw = 1'b0; any_inh = 1'b0; n_fw = 0;
      for (int c = 0; c < NC; c++) begin
         if (c != cur) begin
            any_sh  = any_sh  | ssh[c];
            any_fw  = any_fw  | fw[c];
            any_inh = any_inh | inh[c];
         end
         n_fw += int'(fw[c]);
      end
   end
   always_comb begin
      for (int c = 0; c < NC; c++) begin
         rsh[c] = (c == cur) && any_sh;
         rfw[c] = (c == cur) && any_fw;
      end
   end
   assign mem_supply = bv[cur] && (bop[cur] == 2'd1 || bop[cur] == 2'd2) && !any_inh;

   // scoreboard
   typedef struct packed {
      logic       bv;
      logic [1:0] bop;
      logic [1:0] line;
      logic       fwd;
      logic       inh;
      logic       wb;
      logic       sh;
      logic       mem;
   } exp_t;

   exp_t  exp_q  [$];
   string ltag_q [$];
   string stag_q [$];
   int tests = 0;
   int fails = 0;
   int model [NC][NL];

   task automatic check(string tag, string what, int act, int expv);
      tests++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && exp_q.size() > 0) begin
         exp_t  e;
         string lt, st;
         int    other_wb;
         e  = exp_q.pop_front();
         lt = ltag_q.pop_front();
         st = stag_q.pop_front();
         other_wb = 0;
         for (int c = 0; c < NC; c++) if (c != cur) other_wb += int'(wbv[c]);
         check(lt, "bus valid", int'(bv[cur]), int'(e.bv));
         if (e.bv) begin
            check(lt, "bus op", int'(bop[cur]), int'(e.bop));
            check(lt, "bus line", int'(bln[cur]), int'(e.line));
         end
         check(lt, "writeback", int'(wbv[cur]), int'(e.wb));
         if (e.wb) check(lt, "writeback line", int'(wbl[cur]), int'(e.line));
         check(st, "peer forward", int'(any_fw), int'(e.fwd));
         check(st, "peer inhibit", int'(any_inh), int'(e.inh));
         check(st, "peer shared", int'(any_sh), int'(e.sh));
         check("R12", "memory supply", int'(mem_supply), int'(e.mem));
         check("R12", "forwarders <= 1", int'(n_fw <= 1), 1);
         check("R12", "writeback by non-evicting cache", other_wb, 0);
      end
   end

   // driver: computes expected results from the model, then drives
   task automatic issue(int c, int op, int ln, string ltag, string stag);
      exp_t e;
      int   st;
      e = '0;
      e.line = 2'(ln);
      st = model[c][ln];
      case (op)
         0: if (st == I) begin
               e.bv = 1'b1; e.bop = 2'd1;
               for (int p = 0; p < NC; p++) if (p != c) begin
                  if (model[p][ln] == O || model[p][ln] == M) begin
                     e.fwd = 1'b1; e.inh = 1'b1; e.sh = 1'b1; model[p][ln] = S;
                  end else if (model[p][ln] != I) begin
                     e.sh = 1'b1; model[p][ln] = S;
                  end
               end
               e.mem = !e.fwd;
               model[c][ln] = e.fwd ? O : (e.sh ? S : E);
            end
         1: begin
               if (st == I) begin
                  e.bv = 1'b1; e.bop = 2'd2;
                  for (int p = 0; p < NC; p++) if (p != c) begin
                     if (model[p][ln] == O || model[p][ln] == M) begin
                        e.fwd = 1'b1; e.inh = 1'b1;
                     end
                     model[p][ln] = I;
                  end
                  e.mem = !e.fwd;
               end else if (st == S || st == O) begin
                  e.bv = 1'b1; e.bop = 2'd3;
                  for (int p = 0; p < NC; p++) if (p != c) model[p][ln] = I;
               end
               model[c][ln] = M;
            end
         2: begin
               e.wb = (st == O || st == M);
               model[c][ln] = I;
            end
         default: ;
      endcase
      @(posedge clk);
      #2;
      cur = c;
      lv[c] = 1'b1; lop[c] = 2'(op); lln[c] = 2'(ln);
      exp_q.push_back(e);
      ltag_q.push_back(ltag);
      stag_q.push_back(stag);
      @(posedge clk);
      #2;
      lv[c] = 1'b0;
   endtask

   initial begin
      for (int c = 0; c < NC; c++) begin
         lv[c] = 1'b0; lop[c] = 2'd0; lln[c] = '0;
         for (int l = 0; l < NL; l++) model[c][l] = I;
      end
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet outputs right after reset
      for (int c = 0; c < NC; c++) begin
         check("R1", "bus valid after reset", int'(bv[c]), 0);
         check("R1", "writeback after reset", int'(wbv[c]), 0);
         check("R1", "forward after reset", int'(fw[c]), 0);
      end
      issue(0, 0, 0, "R1", "R1");   // first access misses, no peer answers
      issue(0, 0, 0, "R3", "R3");   // E hit
      issue(1, 0, 0, "R2", "R6");   // E peer reports shared
      issue(0, 1, 0, "R4", "R8");   // S -> upgrade
      issue(1, 0, 0, "R2", "R5");   // M peer forwards, reader owns
      issue(2, 0, 0, "R2", "R5");   // O peer forwards, ownership moves
      issue(0, 1, 0, "R4", "R8");   // upgrade kills O and S
      issue(1, 1, 0, "R4", "R7");   // readx pulls from M
      issue(2, 0, 0, "R2", "R5");
      issue(2, 2, 0, "R9", "R9");   // O evict writes back
      issue(1, 2, 0, "R9", "R9");   // S evict silent
      issue(0, 1, 1, "R4", "R10");  // readx, nobody holds it
      issue(0, 2, 1, "R9", "R10");  // M evict writes back
      issue(0, 0, 1, "R2", "R10");  // refill E from memory
      issue(0, 1, 1, "R4", "R4");   // E write is silent
      issue(1, 0, 1, "R2", "R5");   // proves silent move to M
      issue(1, 0, 2, "R2", "R10");
      issue(2, 1, 2, "R4", "R7");   // E peer invalidated without forward
      issue(1, 0, 2, "R2", "R5");
      issue(0, 2, 2, "R9", "R10");  // evict of Invalid line
      issue(1, 1, 2, "R4", "R8");   // O -> upgrade
      issue(1, 3, 2, "R11", "R11"); // no-op on M line
      issue(2, 3, 1, "R11", "R11"); // no-op on I line
      issue(1, 0, 2, "R3", "R3");   // still a hit
      issue(0, 0, 2, "R2", "R5");   // n1 still M after no-op
      issue(2, 1, 3, "R4", "R10");
      issue(2, 1, 3, "R4", "R4");   // M write hit
      issue(0, 1, 3, "R4", "R7");   // readx from M owner
      issue(0, 2, 3, "R9", "R9");
      issue(1, 0, 3, "R2", "R10");  // memory supplies after writeback
      issue(2, 0, 1, "R2", "R5");   // n1 owns line 1 after earlier fill
      repeat (3) @(posedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL R12 watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule